// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block turns a fast system clock into a stream of one-cycle enable pulses whose average spacing is a fixed-point ratio. The ratio has an integer field and a fraction field counted in sixteenths. A PWM counter, or any other logic that must advance more slowly than the system clock, uses the pulse as its tick enable. The block never produces a derived clock. All downstream logic stays in the system clock domain and advances only in cycles where the pulse is high.

Each interval between pulses lasts either the integer count of cycles or one cycle more. A small fraction accumulator decides which. It adds the fraction field once per pulse, and every time the addition overflows the current interval is stretched by one cycle. The extra cycles are therefore spread evenly, and the long-run ratio is exact. An integer field of zero stands for the largest count, one more than the field's all-ones value. The usable range is therefore 1 up to 256 15/16 with the default widths. Any change to either setting restarts the interval counter and clears the accumulator. Dropping the enable freezes all state until the enable returns.

Top module: `fdiv_tick_gen`

## Requirements
- R1: The effective integer count N equals the integer field, except that a field of 0 means 256. The average ratio is N + frac/16. For example, integer 38 with fraction 3 (raw fixed-point value 611) gives 611 system cycles per 16 pulses.
- R2: Count only enabled cycles in which the settings did not change. The first such cycle after a restart is cycle 1. The k-th pulse after that restart comes on enabled cycle k*N + floor(k*frac/16), and `tick` is low on every other cycle.
- R3: Any 16 consecutive intervals between pulses add up to exactly 16*N + frac system cycles. Each single interval is N or N+1 cycles long, and with frac = 0 every interval is exactly N.
- R4: With integer field 1 and fraction 0 (ratio 1), `tick` is high on every enabled cycle.
- R5: When N is 2 or more, `tick` is never high in two consecutive cycles.
- R6: While `en` is low, `tick` stays low and the interval counter and accumulator hold their values. When `en` returns, counting resumes from where it stopped.
- R7: A cycle in which `div_int` or `div_frac` differs from its value in the previous cycle is a restart. That cycle produces no pulse, whatever the state of `en`. Counting starts again at zero with a cleared accumulator, and that cycle does not count toward R2.
- R8: Reset is synchronous and active low. `tick` is low throughout reset. The settings present while in reset are taken as current, so releasing reset does not cause a restart, and the first cycle after release is enabled cycle 1.
- R9: At the top of the range, with integer field 0 and fraction 15, 16 consecutive intervals take 4111 cycles. With integer field 0 and fraction 0, every interval is 256 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low freezes the divider |
| div_int | input | 8 | Integer part of the ratio, 0 means 256 |
| div_frac | input | 4 | Fractional part of the ratio in sixteenths |
| tick | output | 1 | One-cycle enable pulse |

## Verification
The embedded assertions check, on every cycle, the properties that are local in time. A frozen divider keeps its counter and accumulator. A settings change clears both on the next edge. The accumulator moves only on a pulse. The counter never passes the current interval's last value. No two pulses are adjacent once N is at least 2. The exact placement of each pulse and the 16-interval totals depend on long histories of settings, enables and restarts. Only the bench's scenarios show these: it predicts the pulse cycle from the closed-form formula and measures spans over sixteen intervals, including at both ends of the ratio range.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

   // How an all-zero integer field is read
   typedef enum logic [0:0] {
      ZERO_IS_MAX = 1'b0,   // 0 selects 2**INT_W
      ZERO_IS_ONE = 1'b1    // 0 is clamped to a ratio of one
   } zero_mode_e;

endpackage

// File: rtl/fdiv_setting_watch.sv
module fdiv_setting_watch #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              restart
);

   localparam int SET_W = INT_W + FRAC_W;

   logic [SET_W-1:0] last_q;
   logic [SET_W-1:0] now_w;

   assign now_w = {div_int, div_frac};

   // Synchronous reset loads the live settings so release causes no restart
   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= now_w;
      else        last_q <= now_w;
   end

   assign restart = rst_n && (now_w != last_q);

endmodule

// File: rtl/fdiv_frac_accum.sv
module fdiv_frac_accum #(
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   input  logic [FRAC_W-1:0] frac,
   output logic              carry,
   output logic [FRAC_W-1:0] acc
);

   logic [FRAC_W:0] sum_w;

   assign sum_w = {1'b0, acc} + {1'b0, frac};
   assign carry = sum_w[FRAC_W];

   always_ff @(posedge clk) begin
      if (!rst_n || clear) acc <= '0;
      else if (advance)    acc <= sum_w[FRAC_W-1:0];
   end

endmodule

// File: rtl/fdiv_interval.sv
module fdiv_interval #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [CNT_W-1:0] last_val,
   output logic             at_end,
   output logic [CNT_W-1:0] cnt
);

   assign at_end = (cnt == last_val);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt <= '0;
      else if (run) begin
         if (at_end) cnt <= '0;
         else        cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/fdiv_tick_gen.sv
module fdiv_tick_gen #(
   parameter int                  INT_W     = 8,
   parameter int                  FRAC_W    = 4,
   parameter fdiv_pkg::zero_mode_e ZERO_MODE = fdiv_pkg::ZERO_IS_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              tick
);

   localparam int CNT_W = INT_W + 1;

   // Elaboration-time parameter checks
   if (INT_W < 1 || INT_W > 16) begin : g_bad_int
      $error("fdiv_tick_gen: INT_W out of range");
   end
   if (FRAC_W < 1 || FRAC_W > 8) begin : g_bad_frac
      $error("fdiv_tick_gen: FRAC_W out of range");
   end

   logic             restart;
   logic             carry;
   logic [FRAC_W-1:0] acc;
   logic [CNT_W-1:0] n_eff;
   logic [CNT_W-1:0] last_val;
   logic [CNT_W-1:0] cnt;
   logic             at_end;
   logic             run;

   // Effective integer count: variant chosen by parameter
   if (ZERO_MODE == fdiv_pkg::ZERO_IS_MAX) begin : g_zero_max
      assign n_eff = (div_int == '0) ? CNT_W'(1) << INT_W : {1'b0, div_int};
   end else begin : g_zero_one
      assign n_eff = (div_int == '0) ? CNT_W'(1) : {1'b0, div_int};
   end

   // Interval ends on count N-1, stretched by one when the fraction carries
   assign last_val = n_eff - CNT_W'(1) + CNT_W'(carry);
   assign run      = rst_n && en && !restart;
   assign tick     = run && at_end;

   fdiv_setting_watch #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_int  (div_int),
      .div_frac (div_frac),
      .restart  (restart)
   );

   fdiv_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (restart),
      .advance (tick),
      .frac    (div_frac),
      .carry   (carry),
      .acc     (acc)
   );

   fdiv_interval #(.CNT_W(CNT_W)) u_interval (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (restart),
      .run      (run),
      .last_val (last_val),
      .at_end   (at_end),
      .cnt      (cnt)
   );

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !restart) |=> ($stable(cnt) && $stable(acc)));  // R6

   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0 && acc == '0));  // R7

   AST_ACC_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(acc));  // R3

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (cnt <= last_val));  // R3

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && n_eff >= CNT_W'(2)) |=> !tick);  // R5

endmodule

// File: tb/fdiv_tick_gen_test.sv
module fdiv_tick_gen_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] div_int = 8'd1;
   logic [3:0] div_frac = 4'd0;
   logic       tick;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference model state
   int         en_cnt = 0;
   int         k_seen = 0;
   logic [7:0] m_int  = 8'd1;
   logic [3:0] m_frac = 4'd0;
   logic       last_tick = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fdiv_tick_gen uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .div_int  (div_int),
      .div_frac (div_frac),
      .tick     (tick)
   );

   function automatic int n_of(input logic [7:0] v);
      return (v == 8'd0) ? 256 : int'(v);
   endfunction

   function automatic int due(input int k, input int n, input int f);
      return k * n + (k * f) / 16;
   endfunction

   task automatic check_bit(input logic act, input logic exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: tick=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_int(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: value=%0d expected %0d", req, act, exp);
      end
   endtask

   // one cycle: drive at the falling edge, predict and compare before the rising edge
   task automatic cycle(input logic r, input logic e, input logic [7:0] di,
                        input logic [3:0] df, input string req);
      logic exp;
      @(negedge clk);
      rst_n = r; en = e; div_int = di; div_frac = df;
      #1;
      exp = 1'b0;
      if (!r) begin
         en_cnt = 0; k_seen = 0; m_int = di; m_frac = df;
      end else if (di != m_int || df != m_frac) begin
         en_cnt = 0; k_seen = 0; m_int = di; m_frac = df;
      end else if (e) begin
         en_cnt++;
         if (en_cnt == due(k_seen + 1, n_of(di), int'(df))) begin
            exp = 1'b1;
            k_seen++;
         end
      end
      last_tick = tick;
      check_bit(tick, exp, req);
   endtask

   // span in cycles covered by 16 consecutive intervals
   task automatic measure(input logic [7:0] di, input logic [3:0] df,
                          input string req, output int span);
      int seen  = 0;
      int cyc   = 0;
      int first = 0;
      span = -1;
      while (seen < 17) begin
         cycle(1'b1, 1'b1, di, df, req);
         cyc++;
         if (last_tick) begin
            seen++;
            if (seen == 1)  first = cyc;
            if (seen == 17) span = cyc - first;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int span;
      void'($urandom(32'd24681));

      // R8: reset holds tick low even while enabled
      for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 8'd1, 4'd0, "R8");
      // R4: ratio one ticks every enabled cycle; R8 first cycle after release is cycle 1
      for (int i = 0; i < 10; i++) cycle(1'b1, 1'b1, 8'd1, 4'd0, "R4");

      // R2/R5: small ratio with fraction
      for (int i = 0; i < 120; i++) cycle(1'b1, 1'b1, 8'd3, 4'd5, "R2");
      // N=1 with fraction: intervals of 1 or 2
      for (int i = 0; i < 60; i++) cycle(1'b1, 1'b1, 8'd1, 4'd9, "R2");

      // R1: ratio 38 3/16 gives 611 cycles over 16 intervals
      measure(8'd38, 4'd3, "R1", span);
      check_int(span, 611, "R1");
      // R3: exact total for another ratio, and fraction zero
      measure(8'd7, 4'd11, "R3", span);
      check_int(span, 16 * 7 + 11, "R3");
      measure(8'd5, 4'd0, "R3", span);
      check_int(span, 80, "R3");

      // R9: top of the range
      measure(8'd0, 4'd15, "R9", span);
      check_int(span, 4111, "R9");
      measure(8'd0, 4'd0, "R9", span);
      check_int(span, 16 * 256, "R9");

      // R6: freeze mid-interval, then resume
      for (int i = 0; i < 13; i++) cycle(1'b1, 1'b1, 8'd10, 4'd6, "R6");
      for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0, 8'd10, 4'd6, "R6");
      for (int i = 0; i < 60; i++) cycle(1'b1, 1'b1, 8'd10, 4'd6, "R6");

      // R7: change while disabled and while running, including one-cycle blips
      for (int i = 0; i < 9; i++) cycle(1'b1, 1'b1, 8'd4, 4'd2, "R7");
      cycle(1'b1, 1'b0, 8'd4, 4'd3, "R7");
      for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, 8'd4, 4'd3, "R7");
      for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1, 8'd4, 4'd3, "R7");
      cycle(1'b1, 1'b1, 8'd1, 4'd3, "R7");
      for (int i = 0; i < 20; i++) cycle(1'b1, 1'b1, 8'd4, 4'd3, "R7");

      // R8: reset mid-run with new settings taken during reset
      for (int i = 0; i < 7; i++) cycle(1'b1, 1'b1, 8'd6, 4'd1, "R8");
      for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1, 8'd2, 4'd8, "R8");
      for (int i = 0; i < 40; i++) cycle(1'b1, 1'b1, 8'd2, 4'd8, "R8");

      // Constrained random segments (R2, R5, R6, R7)
      for (int s = 0; s < 40; s++) begin
         logic [7:0] ri;
         logic [3:0] rf;
         ri = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'(1 + $urandom % 12);
         rf = 4'($urandom % 16);
         for (int i = 0; i < 250; i++) begin
            logic e;
            e = ($urandom % 10) != 0;
            if ($urandom % 200 == 0) rf = 4'($urandom % 16);
            cycle(1'b1, e, ri, rf, "R2");
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule